// File: doc/BRIEF.md
# Filtered Reset Pulse Sequencer

This block turns an asynchronous, possibly noisy, active-low reset pin into a clean internal reset for a small processor core. Everything runs on the core's oscillator clock. The pin first passes through a two-stage synchronizer. A run-length filter then discards low pulses that are too short to be a real reset request. Once a request is accepted, the block raises an internal reset and holds it for a minimum number of cycles. If the pin stays low past that minimum, the reset lasts until the pin returns high.

While the internal reset is active, the data strobe is held low and the address strobe flips on every rising clock edge, so the external bus sees a known pattern. After the reset drops, a fixed release delay runs. At the end of that delay the block issues a one-cycle fetch enable, which tells the core to begin fetching at a fixed start vector.

A separate request input serves power-on and watchdog sources. It starts the same sequence and also drives an output that can pull the reset pin low for a configured number of cycles.

Top module: `reset_pulse_seq`

## Requirements
- R1: A reset pin low for 1, 2 or 3 consecutive rising clock edges never raises `rst_int` or `fetch_en`.
- R2: If the pin is low for at least 4 consecutive rising edges, with the first of them counted as edge 1, `rst_int` rises on edge 7. That is two synchronizer stages, four filter edges, then the latch on the fifth edge after the low is first seen.
- R3: Once raised, `rst_int` stays high for at least 18 clock cycles.
- R4: If the pin is still low when 18 cycles have elapsed, `rst_int` stays high until the third rising edge after the pin returns high. A pin pulse of L cycles (L at least 4) therefore gives max(18, L-4) cycles of reset.
- R5: `ds_n` is 0 in exactly the cycles where `rst_int` is 1, and 1 otherwise.
- R6: `as_out` is 1 while `rst_int` is 0. While `rst_int` is 1 it inverts on every rising edge, and it is 0 in the first reset cycle.
- R7: `fetch_en` is high for exactly one cycle, 7 rising edges (REL_DLY) after the edge at which `rst_int` falls. `start_pc` equals 16'h000C.
- R8: A high `wake_req` sampled on a rising edge raises `rst_int` on that same edge. The reset then runs the same hold, strobe and release sequence.
- R9: The edge that samples `wake_req` high also drives `pin_drive_n` low. It stays low for exactly 32 cycles (PIN_DRV_CYC).
- R10: If the pin returns high inside the filter window, the filter count clears. Two 3-cycle lows separated by one high cycle cause no reset.
- R11: While `arst_n` is low, the outputs are: `rst_int`=0, `ds_n`=1, `as_out`=1, `fetch_en`=0 and `pin_drive_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block itself |
| rst_pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| wake_req | input | 1 | Power-on / watchdog reset request, synchronous to clk |
| rst_int | output | 1 | Clean internal reset to the core, active high |
| ds_n | output | 1 | Data strobe, held low during reset |
| as_out | output | 1 | Address strobe, toggling during reset |
| fetch_en | output | 1 | One-cycle pulse starting instruction fetch |
| start_pc | output | PC_W (16) | Fetch start vector |
| pin_drive_n | output | 1 | Active-low drive for pulling the reset pin low |

## Verification
Take the pin falling just after a falling clock edge as the reference, and number the following rising edges 1, 2, and so on. The bench then expects `rst_int` on edge 7, release on edge 7 plus the hold length, and `fetch_en` on the release edge plus 7. A `wake_req` seen on edge 1 raises the reset and `pin_drive_n` on that same edge. The driver works out this per-edge trace from the requirements and queues it before applying the stimulus. The monitor then compares one queued item one nanosecond after each rising edge, so every expected value lands on the edge whose register produces it.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_REL  = 2'd2
    } rps_state_e;

    localparam int unsigned DEF_FILT_LEN = 4;
    localparam int unsigned DEF_HOLD_CYC = 18;
    localparam int unsigned DEF_REL_DLY  = 7;
    localparam int unsigned DEF_DRV_CYC  = 32;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '1;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/rps_filter.sv
module rps_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic low_i,
    input  logic clear_i,
    output logic armed_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_s;

    filt_s d, q;

    always_comb begin
        d = q;
        if (clear_i || !low_i) begin
            d.cnt = '0;
        end else if (q.cnt != FULL) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign armed_o = (q.cnt == FULL);
endmodule

// File: rtl/rps_core.sv
module rps_core
    import rps_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 18,
    parameter int unsigned REL_DLY  = 7
) (
    input  logic clk,
    input  logic arst_n,
    input  logic armed_i,
    input  logic low_i,
    input  logic req_i,
    output logic clear_o,
    output logic rst_o,
    output logic ds_n_o,
    output logic as_o,
    output logic fetch_o
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam int unsigned RW = $clog2(REL_DLY + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);
    localparam logic [RW-1:0] REL_LOAD = RW'(REL_DLY);

    typedef struct packed {
        rps_state_e    state;
        logic [HW-1:0] hold;
        logic [RW-1:0] rel;
        logic          rst;
        logic          ds_n;
        logic          as_o;
        logic          fetch;
    } core_s;

    core_s d, q;
    logic  start;

    always_comb begin
        d       = q;
        d.fetch = 1'b0;
        start   = req_i || (armed_i && (q.state != ST_HOLD));

        if (start) begin
            d.state = ST_HOLD;
            d.hold  = {{(HW-1){1'b0}}, 1'b1};
            d.rel   = '0;
        end else begin
            unique case (q.state)
                ST_HOLD: begin
                    if (q.hold != HOLD_MAX) d.hold = q.hold + 1'b1;
                    if ((q.hold == HOLD_MAX) && !low_i) begin
                        d.state = ST_REL;
                        d.rel   = REL_LOAD;
                    end
                end
                ST_REL: begin
                    if (q.rel <= {{(RW-1){1'b0}}, 1'b1}) begin
                        d.fetch = 1'b1;
                        d.rel   = '0;
                        d.state = ST_IDLE;
                    end else begin
                        d.rel = q.rel - 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end

        d.rst  = (d.state == ST_HOLD);
        d.ds_n = !d.rst;
        d.as_o = d.rst ? !q.as_o : 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q.state <= ST_IDLE;
            q.hold  <= '0;
            q.rel   <= '0;
            q.rst   <= 1'b0;
            q.ds_n  <= 1'b1;
            q.as_o  <= 1'b1;
            q.fetch <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign clear_o = (q.state == ST_HOLD);
    assign rst_o   = q.rst;
    assign ds_n_o  = q.ds_n;
    assign as_o    = q.as_o;
    assign fetch_o = q.fetch;
endmodule

// File: rtl/rps_pindrv.sv
module rps_pindrv #(
    parameter int unsigned DRV_CYC = 32
) (
    input  logic clk,
    input  logic arst_n,
    input  logic req_i,
    output logic drv_n_o
);
    localparam int unsigned DW = $clog2(DRV_CYC + 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          drv_n;
    } drv_s;

    drv_s d, q;

    always_comb begin
        d = q;
        if (req_i)              d.cnt = DW'(DRV_CYC);
        else if (q.cnt != '0)   d.cnt = q.cnt - 1'b1;
        d.drv_n = (d.cnt == '0);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q.cnt   <= '0;
            q.drv_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign drv_n_o = q.drv_n;
endmodule

// File: rtl/reset_pulse_seq.sv
module reset_pulse_seq
    import rps_pkg::*;
#(
    parameter int unsigned FILT_LEN    = DEF_FILT_LEN,
    parameter int unsigned HOLD_CYC    = DEF_HOLD_CYC,
    parameter int unsigned REL_DLY     = DEF_REL_DLY,
    parameter int unsigned PIN_DRV_CYC = DEF_DRV_CYC,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PC_W        = 16,
    parameter logic [PC_W-1:0] START_VEC = 16'h000C
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            rst_pin_n,
    input  logic            wake_req,
    output logic            rst_int,
    output logic            ds_n,
    output logic            as_out,
    output logic            fetch_en,
    output logic [PC_W-1:0] start_pc,
    output logic            pin_drive_n
);
    logic pin_sync;
    logic armed;
    logic clear;

    rps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .async_i (rst_pin_n),
        .sync_o  (pin_sync)
    );

    rps_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .arst_n  (arst_n),
        .low_i   (!pin_sync),
        .clear_i (clear),
        .armed_o (armed)
    );

    rps_core #(.HOLD_CYC(HOLD_CYC), .REL_DLY(REL_DLY)) u_core (
        .clk     (clk),
        .arst_n  (arst_n),
        .armed_i (armed),
        .low_i   (!pin_sync),
        .req_i   (wake_req),
        .clear_o (clear),
        .rst_o   (rst_int),
        .ds_n_o  (ds_n),
        .as_o    (as_out),
        .fetch_o (fetch_en)
    );

    rps_pindrv #(.DRV_CYC(PIN_DRV_CYC)) u_pindrv (
        .clk     (clk),
        .arst_n  (arst_n),
        .req_i   (wake_req),
        .drv_n_o (pin_drive_n)
    );

    assign start_pc = START_VEC;
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int unsigned HOLD_CYC = 18
) (
    input logic clk,
    input logic arst_n,
    input logic rst_pin_n,
    input logic wake_req,
    input logic rst_int,
    input logic ds_n,
    input logic as_out,
    input logic fetch_en,
    input logic pin_drive_n
);
    localparam int unsigned RCW = $clog2(HOLD_CYC + 2);
    localparam logic [RCW-1:0] RUN_SAT = RCW'(HOLD_CYC + 1);

    logic [RCW-1:0] run_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                 run_q <= '0;
        else if (!rst_int)           run_q <= '0;
        else if (run_q != RUN_SAT)   run_q <= run_q + 1'b1;
    end

    // R3: a reset never ends before the minimum hold
    a_r3_min_hold: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_int) |-> (run_q >= RCW'(HOLD_CYC)));

    // R4: reset only ends once the pin had returned high
    a_r4_pin_high_at_end: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_int) |-> $past(rst_pin_n, 3));

    // R5: data strobe low exactly during reset
    a_r5_ds_tracks_reset: assert property (@(posedge clk) disable iff (!arst_n)
        ds_n == !rst_int);

    // R6: address strobe idles high and flips each cycle of reset
    a_r6_as_idle_high: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_int |-> as_out);
    a_r6_as_toggles: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_int && $past(rst_int)) |-> (as_out != $past(as_out)));

    // R7: fetch enable is a single pulse outside reset
    a_r7_fetch_single: assert property (@(posedge clk) disable iff (!arst_n)
        fetch_en |=> !fetch_en);
    a_r7_fetch_not_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
        fetch_en |-> !rst_int);

    // R8 / R9: request raises reset and pin drive on its edge
    a_r8_req_starts_reset: assert property (@(posedge clk) disable iff (!arst_n)
        wake_req |=> rst_int);
    a_r9_req_drives_pin: assert property (@(posedge clk) disable iff (!arst_n)
        wake_req |=> !pin_drive_n);
endmodule

bind reset_pulse_seq rps_checker #(.HOLD_CYC(HOLD_CYC)) u_rps_checker (
    .clk         (clk),
    .arst_n      (arst_n),
    .rst_pin_n   (rst_pin_n),
    .wake_req    (wake_req),
    .rst_int     (rst_int),
    .ds_n        (ds_n),
    .as_out      (as_out),
    .fetch_en    (fetch_en),
    .pin_drive_n (pin_drive_n)
);

// File: tb/test_reset_pulse_seq.sv
`timescale 1ns/1ps
module test_reset_pulse_seq;
    localparam int HOLD = 18;
    localparam int REL  = 7;
    localparam int DRV  = 32;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        wake_req = 1'b0;
    logic        rst_int, ds_n, as_out, fetch_en, pin_drive_n;
    logic [15:0] start_pc;

    typedef struct packed {
        logic rst;
        logic ds_n;
        logic as_o;
        logic fetch;
        logic pdrv;
    } exp_s;

    exp_s  exp_q[$];
    string tag_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    always #2.5 clk = ~clk;

    reset_pulse_seq i_reset_pulse_seq (
        .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .wake_req(wake_req),
        .rst_int(rst_int), .ds_n(ds_n), .as_out(as_out), .fetch_en(fetch_en),
        .start_pc(start_pc), .pin_drive_n(pin_drive_n)
    );

    // monitor: one expected item per rising edge, sampled 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_s  e;
                string t;
                bit    bad;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = 0;
                n_vec++;
                if (rst_int !== e.rst) begin
                    $display("FAIL %s rst_int got %0b exp %0b", t, rst_int, e.rst); bad = 1;
                end
                if (ds_n !== e.ds_n) begin
                    $display("FAIL R5 ds_n got %0b exp %0b", ds_n, e.ds_n); bad = 1;
                end
                if (as_out !== e.as_o) begin
                    $display("FAIL R6 as_out got %0b exp %0b", as_out, e.as_o); bad = 1;
                end
                if (fetch_en !== e.fetch) begin
                    $display("FAIL R7 fetch_en got %0b exp %0b", fetch_en, e.fetch); bad = 1;
                end
                if (pin_drive_n !== e.pdrv) begin
                    $display("FAIL R9 pin_drive_n got %0b exp %0b", pin_drive_n, e.pdrv); bad = 1;
                end
                if (bad) n_bad++;
            end
        end
    end

    // push expected trace: reset over edges [r0, r0+h-1], fetch at r0+h+REL
    task automatic push_trace(int n, int r0, int h, int d0, int dl, string t);
        for (int k = 1; k <= n; k++) begin
            exp_s e;
            e.rst   = (h > 0) && (k >= r0) && (k < r0 + h);
            e.ds_n  = !e.rst;
            e.as_o  = e.rst ? (((k - r0) % 2) != 0) : 1'b1;
            e.fetch = (h > 0) && (k == r0 + h + REL);
            e.pdrv  = !((dl > 0) && (k >= d0) && (k < d0 + dl));
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
    endtask

    task automatic pin_pulse(int len, string t);
        int h;
        @(negedge clk);
        h = (len >= 4) ? ((len - 4 > HOLD) ? len - 4 : HOLD) : 0;
        push_trace((h > 0) ? 7 + h + REL + 3 : len + 10, 7, h, 0, 0, t);
        rst_pin_n = 1'b0;
        repeat (len) @(negedge clk);
        rst_pin_n = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        // R11: reset state while arst_n is held low
        repeat (3) @(negedge clk);
        n_vec++;
        if ({rst_int, ds_n, as_out, fetch_en, pin_drive_n} !== 5'b01101) begin
            n_bad++;
            $display("FAIL R11 outputs got %05b exp 01101",
                     {rst_int, ds_n, as_out, fetch_en, pin_drive_n});
        end
        arst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: fixed start vector
        n_vec++;
        if (start_pc !== 16'h000C) begin
            n_bad++;
            $display("FAIL R7 start_pc got %h exp 000c", start_pc);
        end

        // R1: short glitches rejected
        pin_pulse(1, "R1");
        pin_pulse(2, "R1");
        pin_pulse(3, "R1");

        // R10: a high cycle inside the window clears the count
        @(negedge clk);
        push_trace(20, 7, 0, 0, 0, "R10");
        rst_pin_n = 1'b0; repeat (3) @(negedge clk);
        rst_pin_n = 1'b1; @(negedge clk);
        rst_pin_n = 1'b0; repeat (3) @(negedge clk);
        rst_pin_n = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);

        // R2/R3: accepted pulses hold the minimum count
        pin_pulse(4, "R2");
        pin_pulse(5, "R2");
        pin_pulse(18, "R3");
        // R4: long pulse stretches the reset
        pin_pulse(40, "R4");

        // R8/R9: request input
        @(negedge clk);
        push_trace(DRV + 4, 1, HOLD, 1, DRV, "R8");
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule